// File: doc/BRIEF.md
# Circular Result Buffer Writer

This block sits between a conversion sequencer and a RAM. Each conversion result arrives with a rank tag, which is its position in the scan sequence. The block writes the result into a buffer of `chans × depth` entries in interleaved form. Entry `set × chans + rank` holds the sample of that rank from sample set `set`. After the last entry is written, writing continues at entry 0 and overwrites older data, so the transfer never stops.

Two sticky events let firmware work on one half of the buffer while the other half fills:

- **Half-buffer** is raised when the first half has been written.
- **Full-buffer** is raised at the end of every lap.

A third sticky flag reports a result that could not be taken. Each flag is cleared by writing 1 to it and has its own interrupt enable. The next write position is visible on a status output.

One result is held in a holding stage whose control is a two-state machine:

- **ST_EMPTY**: no result is held.
- **ST_PEND**: a result is held and the memory write enable is asserted.

The transitions are:

- **accept**: EMPTY→PEND on a taken result with a valid tag.
- **drain**: PEND→EMPTY when the memory takes the write and nothing new is loaded.
- **drain-and-reload**: PEND→PEND when the write completes and a new result is taken in the same cycle.
- **flush**: any state →EMPTY on a configuration change.

Top module: `ringbuf_result_writer`

## Requirements
- R1: A result with rank tag `t` taken during sample set `s` is written to address `s*chans + t`, with its data unchanged.
- R2: After the write to address `chans*depth - 1` the sample set returns to 0, so the next set is written from address 0 onward and older data is overwritten with no pause.
- R3: Flag bit 0 (half) is set in the cycle after a completed write to address `floor(chans*depth/2) - 1`.
- R4: Flag bit 1 (full) is set in the cycle after a completed write to address `chans*depth - 1`, on every lap.
- R5: A cycle with `res_valid` high and `res_ready` low (other than a configuration-change cycle) sets flag bit 2 (overrun). That result is discarded: each valid cycle counts as a new result.
- R6: `res_ready` is high when nothing is held or the held result is being written in this cycle. While `mem_ready` is low, `mem_we` stays high with a stable address and data.
- R7: Flags are sticky. A 1 on a bit of `flag_clr` clears that bit at the next edge, and a new set event in the same cycle wins over the clear.
- R8: `irq` is high exactly when some flag bit is set and its `irq_en` bit is 1.
- R9: A change of `cfg_chans` or `cfg_depth` from the held value has three effects in that cycle: `res_ready` and `mem_we` are low, the held result is dropped, and at the next edge all flags clear and the write pointer returns to 0.
- R10: A result taken with tag ≥ `chans` is dropped. No write is made and the write pointer does not change.
- R11: `wptr` equals the base of the current sample set plus the next expected rank. After a write of tag `t` < `chans-1` it is base + `t` + 1, and after tag `chans-1` it is the next set's base.
- R12: After reset, `mem_we` is low, `res_ready` is high, and flags, `irq` and `wptr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_chans | input | CH_W | Channels per sample set, 1..MAX_CHANS |
| cfg_depth | input | DP_W | Sample sets in the buffer, 2..MAX_DEPTH |
| res_valid | input | 1 | A result is offered this cycle |
| res_ready | output | 1 | The offered result is taken this cycle |
| res_tag | input | TAG_W | Rank of the offered result |
| res_data | input | DATA_W | Conversion value |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory takes the write this cycle |
| flag_clr | input | 3 | Write-1-to-clear per flag (0 half, 1 full, 2 overrun) |
| irq_en | input | 3 | Interrupt enable per flag |
| flags | output | 3 | Sticky flags (0 half, 1 full, 2 overrun) |
| irq | output | 1 | Combined interrupt |
| wptr | output | ADDR_W | Address of the next expected write |

## Verification
The assertions assume the configuration inputs stay in their legal ranges: channels from 1 to the maximum and depth from 2 to the maximum. They also assume that a configuration change is a deliberate event and not noise on every cycle. The stimulus picks configurations only from a fixed legal list and holds each one for hundreds of cycles. Rank tags mostly follow a wrapping in-order sequencer, with occasional random tags that include out-of-range ones. Memory backpressure and flag clears are random, so overrun, stalls and same-cycle set/clear all occur while wraps and half-buffer points are crossed.

// File: rtl/rbw_pkg.sv
package rbw_pkg;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_PEND  = 1'b1
    } hold_state_t;

    localparam int NFLAGS  = 3;
    localparam int FLG_HT  = 0;
    localparam int FLG_TC  = 1;
    localparam int FLG_OVR = 2;

endpackage

// File: rtl/rbw_hold_ctrl.sv
module rbw_hold_ctrl
    import rbw_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 2,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [CH_W-1:0]   chans,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    input  logic              mem_ready,
    output logic              res_ready,
    output logic              hold_we,
    output logic [TAG_W-1:0]  hold_tag,
    output logic [DATA_W-1:0] hold_data,
    output logic              wr_done,
    output logic              ovr_evt
);

    hold_state_t state_q, state_d;
    logic        tag_ok;
    logic        accept;
    logic [CH_W:0] tag_x;

    assign tag_x  = (CH_W+1)'(res_tag);
    assign tag_ok = tag_x < {1'b0, chans};
    assign accept = res_valid && res_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (flush) begin
                    state_d = ST_EMPTY;
                end else if (accept && tag_ok) begin
                    state_d = ST_PEND;
                end
            end
            ST_PEND: begin
                if (flush) begin
                    state_d = ST_EMPTY;
                end else if (accept && tag_ok) begin
                    state_d = ST_PEND;
                end else if (mem_ready) begin
                    state_d = ST_EMPTY;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        res_ready = 1'b0;
        hold_we   = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                res_ready = !flush;
                hold_we   = 1'b0;
            end
            ST_PEND: begin
                res_ready = mem_ready && !flush;
                hold_we   = !flush;
            end
            default: begin
                res_ready = 1'b0;
                hold_we   = 1'b0;
            end
        endcase
        wr_done = hold_we && mem_ready;
        ovr_evt = res_valid && !res_ready && !flush;
    end

    // holding stage payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_tag  <= '0;
            hold_data <= '0;
        end else if (accept && tag_ok) begin
            hold_tag  <= res_tag;
            hold_data <= res_data;
        end
    end

endmodule

// File: rtl/rbw_addr_gen.sv
module rbw_addr_gen #(
    parameter int ADDR_W = 6,
    parameter int CH_W   = 3,
    parameter int DP_W   = 5,
    parameter int TAG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [CH_W-1:0]   chans,
    input  logic [DP_W-1:0]   depth,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_done,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] wptr,
    output logic [ADDR_W:0]   total,
    output logic              ht_evt,
    output logic              tc_evt
);

    logic [ADDR_W-1:0] set_base_q;
    logic [TAG_W-1:0]  rank_q;
    logic [ADDR_W:0]   half;
    logic [ADDR_W:0]   next_base_x;
    logic              is_last_rank;
    logic              set_end;

    assign total        = (ADDR_W+1)'(chans) * (ADDR_W+1)'(depth);
    assign half         = total >> 1;
    assign wr_addr      = set_base_q + ADDR_W'(wr_tag);
    assign wptr         = set_base_q + ADDR_W'(rank_q);
    assign is_last_rank = (CH_W'(wr_tag) == (chans - CH_W'(1)));
    assign next_base_x  = {1'b0, set_base_q} + (ADDR_W+1)'(chans);
    assign set_end      = (next_base_x == total);

    assign ht_evt = wr_done && ({1'b0, wr_addr} == (half - (ADDR_W+1)'(1)));
    assign tc_evt = wr_done && ({1'b0, wr_addr} == (total - (ADDR_W+1)'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_base_q <= '0;
            rank_q     <= '0;
        end else if (flush) begin
            set_base_q <= '0;
            rank_q     <= '0;
        end else if (wr_done) begin
            if (is_last_rank) begin
                set_base_q <= set_end ? '0 : next_base_x[ADDR_W-1:0];
                rank_q     <= '0;
            end else begin
                rank_q     <= wr_tag + TAG_W'(1);
            end
        end
    end

endmodule

// File: rtl/rbw_flags.sv
module rbw_flags #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [NF-1:0] set_evt,
    input  logic [NF-1:0] clr,
    input  logic [NF-1:0] en,
    output logic [NF-1:0] flags,
    output logic          irq
);

    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (flush) begin
                flags[i] <= 1'b0;
            end else if (set_evt[i]) begin
                flags[i] <= 1'b1;
            end else if (clr[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

    assign irq = |(flags & en);

endmodule

// File: rtl/ringbuf_result_writer.sv
module ringbuf_result_writer
    import rbw_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAX_CHANS = 4,
    parameter int MAX_DEPTH = 16,
    localparam int TAG_W  = (MAX_CHANS > 1) ? $clog2(MAX_CHANS) : 1,
    localparam int CH_W   = $clog2(MAX_CHANS + 1),
    localparam int DP_W   = $clog2(MAX_DEPTH + 1),
    localparam int ADDR_W = $clog2(MAX_CHANS * MAX_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_W-1:0]   cfg_chans,
    input  logic [DP_W-1:0]   cfg_depth,
    input  logic              res_valid,
    output logic              res_ready,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    input  logic              mem_ready,
    input  logic [2:0]        flag_clr,
    input  logic [2:0]        irq_en,
    output logic [2:0]        flags,
    output logic              irq,
    output logic [ADDR_W-1:0] wptr
);

    logic [CH_W-1:0]   chans_q;
    logic [DP_W-1:0]   depth_q;
    logic              flush;
    logic              wr_done;
    logic              ovr_evt;
    logic              ht_evt;
    logic              tc_evt;
    logic [TAG_W-1:0]  hold_tag;
    logic [ADDR_W:0]   buf_total;
    logic [NFLAGS-1:0] set_evt;

    // configuration capture; any change flushes the transfer
    assign flush = (cfg_chans != chans_q) || (cfg_depth != depth_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chans_q <= CH_W'(MAX_CHANS);
            depth_q <= DP_W'(MAX_DEPTH);
        end else begin
            chans_q <= cfg_chans;
            depth_q <= cfg_depth;
        end
    end

    rbw_hold_ctrl #(
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .CH_W   (CH_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .chans     (chans_q),
        .res_valid (res_valid),
        .res_tag   (res_tag),
        .res_data  (res_data),
        .mem_ready (mem_ready),
        .res_ready (res_ready),
        .hold_we   (mem_we),
        .hold_tag  (hold_tag),
        .hold_data (mem_data),
        .wr_done   (wr_done),
        .ovr_evt   (ovr_evt)
    );

    rbw_addr_gen #(
        .ADDR_W (ADDR_W),
        .CH_W   (CH_W),
        .DP_W   (DP_W),
        .TAG_W  (TAG_W)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .chans   (chans_q),
        .depth   (depth_q),
        .wr_tag  (hold_tag),
        .wr_done (wr_done),
        .wr_addr (mem_addr),
        .wptr    (wptr),
        .total   (buf_total),
        .ht_evt  (ht_evt),
        .tc_evt  (tc_evt)
    );

    always_comb begin
        set_evt          = '0;
        set_evt[FLG_HT]  = ht_evt;
        set_evt[FLG_TC]  = tc_evt;
        set_evt[FLG_OVR] = ovr_evt;
    end

    rbw_flags #(
        .NF (NFLAGS)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .set_evt (set_evt),
        .clr     (flag_clr),
        .en      (irq_en),
        .flags   (flags),
        .irq     (irq)
    );

endmodule

// File: rtl/rbw_checker.sv
module rbw_checker #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              res_valid,
    input logic              res_ready,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic [ADDR_W:0]   buf_total,
    input logic [2:0]        flags,
    input logic [2:0]        flag_clr,
    input logic [ADDR_W-1:0] wptr
);

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_ready) |=> (flush || (mem_we && $stable(mem_addr) && $stable(mem_data))));

    p_stall_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_ready) |-> !res_ready);

    p_addr_in_buf_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ({1'b0, mem_addr} < buf_total));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ready && ({1'b0, mem_addr} == buf_total - 1'b1)) |=> (wptr == '0));

    p_full_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ready && ({1'b0, mem_addr} == buf_total - 1'b1)) |=> flags[1]);

    p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready && !flush) |=> flags[2]);

    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((flags == 3'b000) && (wptr == '0)));

    p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!mem_we && !res_ready));

    for (genvar i = 0; i < 3; i++) begin : g_sticky
        p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !flag_clr[i] && !flush) |=> flags[i]);
    end

endmodule

bind ringbuf_result_writer rbw_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_rbw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .buf_total (buf_total),
    .flags     (flags),
    .flag_clr  (flag_clr),
    .wptr      (wptr)
);

// File: tb/ringbuf_result_writer_bench.sv
module ringbuf_result_writer_bench;

    localparam int DATA_W = 16;
    localparam int MAXC   = 4;
    localparam int MAXD   = 16;
    localparam int TAG_W  = 2;
    localparam int CH_W   = 3;
    localparam int DP_W   = 5;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CH_W-1:0]   cfg_chans = 3'd4;
    logic [DP_W-1:0]   cfg_depth = 5'd16;
    logic              res_valid = 1'b0;
    logic              res_ready;
    logic [TAG_W-1:0]  res_tag = '0;
    logic [DATA_W-1:0] res_data = '0;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_data;
    logic              mem_ready = 1'b1;
    logic [2:0]        flag_clr = '0;
    logic [2:0]        irq_en = '0;
    logic [2:0]        flags;
    logic              irq;
    logic [ADDR_W-1:0] wptr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference model state
    bit m_pend;
    int m_data, m_tag, m_base, m_rank, m_ch, m_dp, m_laps;
    bit [2:0] m_flags;
    bit prev_flush, prev_bad_tag;
    bit [2:0] prev_clr;
    int seq_rank;

    always #2 clk = ~clk;

    ringbuf_result_writer #(
        .DATA_W    (DATA_W),
        .MAX_CHANS (MAXC),
        .MAX_DEPTH (MAXD)
    ) u_ringbuf_result_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_chans (cfg_chans),
        .cfg_depth (cfg_depth),
        .res_valid (res_valid),
        .res_ready (res_ready),
        .res_tag   (res_tag),
        .res_data  (res_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_ready (mem_ready),
        .flag_clr  (flag_clr),
        .irq_en    (irq_en),
        .flags     (flags),
        .irq       (irq),
        .wptr      (wptr)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int buf_len(input int ch, input int dp);
        return ch * dp;
    endfunction

    function automatic int slot_addr(input int base, input int tag);
        return base + tag;
    endfunction

    function automatic bit cfg_differs();
        return (int'(cfg_chans) != m_ch) || (int'(cfg_depth) != m_dp);
    endfunction

    task automatic model_reset();
        m_pend = 0; m_data = 0; m_tag = 0; m_base = 0; m_rank = 0;
        m_ch = MAXC; m_dp = MAXD; m_flags = '0; m_laps = 0;
        prev_flush = 0; prev_bad_tag = 0; prev_clr = '0; seq_rank = 0;
    endtask

    // compare outputs in the current cycle with the model
    task automatic compare();
        bit fl;
        string lbl;
        fl = cfg_differs();
        chk(fl ? "R9" : "R6", "res_ready", int'(res_ready),
            int'((!m_pend || mem_ready) && !fl));
        chk(fl ? "R9" : "R6", "mem_we", int'(mem_we), int'(m_pend && !fl));
        if (m_pend && !fl) begin
            lbl = (slot_addr(m_base, m_tag) == 0 && m_laps > 0) ? "R2" : "R1";
            chk(lbl, "mem_addr", int'(mem_addr), slot_addr(m_base, m_tag));
            chk("R1", "mem_data", int'(mem_data), m_data);
        end
        for (int b = 0; b < 3; b++) begin
            lbl = (b == 0) ? "R3" : (b == 1) ? "R4" : "R5";
            if (prev_flush) lbl = "R9";
            else if (prev_clr[b]) lbl = "R7";
            chk(lbl, $sformatf("flags[%0d]", b), int'(flags[b]), int'(m_flags[b]));
        end
        chk("R8", "irq", int'(irq), int'(|(m_flags & irq_en)));
        lbl = prev_flush ? "R9" : (prev_bad_tag ? "R10" : "R11");
        chk(lbl, "wptr", int'(wptr), m_base + m_rank);
    endtask

    // advance the model across the coming clock edge
    task automatic model_step();
        bit fl, rdy, wr;
        bit [2:0] set;
        int a, tot;
        fl = cfg_differs();
        prev_flush = fl;
        prev_clr = flag_clr;
        prev_bad_tag = 0;
        if (fl) begin
            m_ch = int'(cfg_chans); m_dp = int'(cfg_depth);
            m_pend = 0; m_base = 0; m_rank = 0; m_flags = '0;
            return;
        end
        rdy = !m_pend || mem_ready;
        wr  = m_pend && mem_ready;
        set = '0;
        if (wr) begin
            tot = buf_len(m_ch, m_dp);
            a = slot_addr(m_base, m_tag);
            if (a == tot / 2 - 1) set[0] = 1;
            if (a == tot - 1) set[1] = 1;
            if (m_tag == m_ch - 1) begin
                if (m_base + m_ch == tot) begin
                    m_base = 0;
                    m_laps++;
                end else begin
                    m_base = m_base + m_ch;
                end
                m_rank = 0;
            end else begin
                m_rank = m_tag + 1;
            end
        end
        if (res_valid && !rdy) set[2] = 1;
        m_flags = (m_flags & ~flag_clr) | set;
        if (res_valid && rdy && int'(res_tag) < m_ch) begin
            m_pend = 1; m_data = int'(res_data); m_tag = int'(res_tag);
        end else begin
            if (res_valid && rdy) prev_bad_tag = 1;
            if (wr) m_pend = 0;
        end
    endtask

    task automatic run_phase(input int ch, input int dp, input int cycles,
                             input int p_valid, input int p_ready, input bit noise);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            cfg_chans = CH_W'(ch);
            cfg_depth = DP_W'(dp);
            res_valid = (($urandom % 100) < p_valid);
            if (noise && ($urandom % 100) < 5) begin
                res_tag = TAG_W'($urandom % MAXC);
            end else begin
                res_tag = TAG_W'(seq_rank % ch);
            end
            if (res_valid) seq_rank = (seq_rank + 1) % ch;
            res_data  = DATA_W'($urandom);
            mem_ready = (($urandom % 100) < p_ready);
            flag_clr  = noise && (($urandom % 100) < 4) ? 3'($urandom) : 3'b000;
            if (($urandom % 100) < 2) irq_en = 3'($urandom);
            #1;
            compare();
            model_step();
        end
    endtask

    initial begin
        void'($urandom(32'd1357));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk("R12", "mem_we", int'(mem_we), 0);
        chk("R12", "res_ready", int'(res_ready), 1);
        chk("R12", "flags", int'(flags), 0);
        chk("R12", "irq", int'(irq), 0);
        chk("R12", "wptr", int'(wptr), 0);
        rst_n = 1'b1;
        irq_en = 3'b111;
        // directed: in-order stream with free memory crosses half point and wraps (R2, R3, R4)
        run_phase(4, 16, 300, 100, 100, 0);
        // random backpressure, overruns, stray tags and clears
        run_phase(4, 16, 2000, 60, 60, 1);
        run_phase(3, 5, 1500, 55, 70, 1);   // odd length: half point at entry 6
        run_phase(1, 2, 500, 50, 70, 1);
        run_phase(2, 3, 800, 60, 50, 1);
        run_phase(3, 5, 400, 100, 100, 0);
        run_phase(4, 16, 1500, 70, 40, 1);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule